// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block owns the command pins of one single-rank SDR SDRAM device. It covers the period from power-up through mode programming. Out of reset it holds the clock enable low. It then raises the clock enable and waits a parameterised number of cycles for the device to stabilise. After that it issues the start-up commands in a fixed order, with the required spacing between them:

1. a precharge of all banks,
2. two auto-refresh commands,
3. a mode register load.

The mode word is assembled from parameter fields. The defaults give burst length 4, sequential bursts, CAS latency 2 and single-location writes. The target device has 12 row bits, 8 column bits, 4 internal banks and a 16-bit data bus.

Once the last gap has elapsed, `ready` goes high. An interval timer then starts and raises `ref_req` each time its period expires. An external arbiter drains normal traffic and answers with `ref_gnt`. The sequencer then places an auto-refresh command on the pins. `busy` is high for the command and its full recovery gap, so the arbiter can hold off its own commands while a sequencer command is in flight.

The interval timer runs freely and does not wait for the grant. A late grant therefore does not shift the following refresh request.

Top module: `sdram_boot_refresh`

## Requirements
- R1: A synchronous active-high reset drives `cke` low, NOP on the command pins, `addr` and `ba` to zero, `ready` low, `busy` high and `ref_req` low. Releasing reset restarts the whole power-up sequence.
- R2: `cke` goes high on the first clock edge after reset is released. The precharge-all command appears exactly PWRUP_WAIT edges after that, with NOP in every cycle between.
- R3: Precharge-all is driven as {cs_n,ras_n,cas_n,we_n} = 0010, with `addr` bit 10 high and every other address bit low (0x400).
- R4: Auto-refresh (0001) is issued twice during start-up. The first follows the precharge by T_RP edges. The second follows the first by T_RC edges.
- R5: The mode register load (0000) follows the second auto-refresh by T_RC edges. It drives `ba` = 0 and the mode word on `addr`:
  - bits 2:0 carry the burst length code (default 010, length 4);
  - bit 3 carries the burst type (default 0, sequential);
  - bits 6:4 carry the CAS latency (default 010);
  - bits 8:7 are zero;
  - bit 9 selects single-location writes (default 1).
  With the defaults the word is 0x222.
- R6: `ready` rises T_MRD edges after the mode register load and stays high until the next reset.
- R7: `busy` is high from reset until `ready` rises. After a granted refresh it is high for exactly T_RC cycles, starting with the cycle that carries the auto-refresh command.
- R8: `ref_req` rises REFI edges after `ready` rises. Once high, it stays high until a grant is taken.
- R9: A grant is taken when `ref_gnt` is sampled high while `ref_req` is high and `busy` is low. On the next edge the pins carry auto-refresh (0001) and `ref_req` falls.
- R10: `ref_gnt` sampled while `ref_req` is low has no effect: the pins stay NOP and `busy` stays low.
- R11: Refresh requests recur every REFI edges measured from `ready`, regardless of how late each earlier grant came.
- R12: In every cycle without a command the pins carry NOP (0111) with `addr` and `ba` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_gnt | input | 1 | Arbiter permission to issue the pending refresh |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W (2) | Bank address |
| addr | output | ADDR_W (12) | Multiplexed address bus |
| ready | output | 1 | Start-up sequence complete |
| busy | output | 1 | A sequencer command or its recovery gap is in progress |
| ref_req | output | 1 | Refresh pending, waiting for a grant |

## Verification
The bench builds the block with PWRUP_WAIT = 5 and REFI = 40, and keeps the default T_RP, T_RC, T_MRD and mode fields. The short power-up wait lets every cycle of the start-up sequence be compared edge by edge. The short interval brings three refresh periods into reach within a few hundred cycles. Those periods cover:
- a grant held off for several cycles;
- a stray grant with no request pending;
- a grant held high before the request arrives.
Together they show that request timing stays anchored to `ready`.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // Command pin encodings, ordered {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_CKE_ON,
        ST_PRE,
        ST_AR_A,
        ST_AR_B,
        ST_MRS,
        ST_SETTLE,
        ST_IDLE,
        ST_REF_GAP
    } seq_state_e;

endpackage

// File: rtl/sdr_gap_timer.sv
// Loadable down counter; zero means the current gap has elapsed.
module sdr_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    AST_NO_EARLY_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |-> expired)
        else $error("gap timer reloaded before expiry"); // R4

endmodule

// File: rtl/sdr_refresh_timer.sv
// Free-running refresh interval counter with a pending-request flag.
module sdr_refresh_timer #(
    parameter int REFI = 1386
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic take,
    output logic req
);
    localparam int CW = $clog2(REFI + 1);
    localparam logic [CW-1:0] RELOAD = CW'(REFI - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } refi_t;

    refi_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (take)
            nxt_d.pend = 1'b0;
        if (!run) begin
            nxt_d.cnt = RELOAD;
        end else if (cur_q.cnt == '0) begin
            nxt_d.cnt  = RELOAD;
            nxt_d.pend = 1'b1;
        end else begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.cnt  <= RELOAD;
            cur_q.pend <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req = cur_q.pend;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req && !take) |=> req)
        else $error("refresh request dropped without grant"); // R8

    AST_REQ_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        req |-> run)
        else $error("refresh request before start-up done"); // R8

endmodule

// File: rtl/sdram_boot_refresh.sv
module sdram_boot_refresh
    import sdr_seq_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          BA_W       = 2,
    parameter int          AP_BIT     = 10,
    parameter int          PWRUP_WAIT = 10000,
    parameter int          T_RP       = 2,
    parameter int          T_RC       = 7,
    parameter int          T_MRD      = 2,
    parameter int          REFI       = 1386,
    parameter logic [2:0]  BURST_CODE = 3'b010,
    parameter logic        INTERLEAVE = 1'b0,
    parameter logic [2:0]  CAS_LAT    = 3'b010,
    parameter logic        SINGLE_WR  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_gnt,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              busy,
    output logic              ref_req
);
    localparam logic [ADDR_W-1:0] MODE_WORD =
        ADDR_W'({SINGLE_WR, 2'b00, CAS_LAT, INTERLEAVE, BURST_CODE});
    localparam int MAX_GAP_A = (PWRUP_WAIT > T_RC) ? PWRUP_WAIT : T_RC;
    localparam int MAX_GAP_B = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int MAX_GAP   = (MAX_GAP_A > MAX_GAP_B) ? MAX_GAP_A : MAX_GAP_B;
    localparam int CNT_W     = $clog2(MAX_GAP + 1);

    typedef struct packed {
        seq_state_e        state;
        sdr_cmd_e          cmd;
        logic [ADDR_W-1:0] addr;
        logic [BA_W-1:0]   ba;
        logic              cke;
        logic              ready;
        logic              busy;
    } seq_t;

    seq_t             cur_q, nxt_d;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             gap_done;
    logic             take;

    sdr_gap_timer #(.CNT_W(CNT_W)) i_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .expired  (gap_done)
    );

    sdr_refresh_timer #(.REFI(REFI)) i_refi (
        .clk  (clk),
        .rst  (rst),
        .run  (cur_q.ready),
        .take (take),
        .req  (ref_req)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.cmd  = CMD_NOP;
        nxt_d.addr = '0;
        nxt_d.ba   = '0;
        ld         = 1'b0;
        ld_val     = '0;
        take       = 1'b0;
        unique case (cur_q.state)
            ST_CKE_ON: begin
                nxt_d.cke   = 1'b1;
                ld          = 1'b1;
                ld_val      = CNT_W'(PWRUP_WAIT - 1);
                nxt_d.state = ST_PRE;
            end
            ST_PRE: if (gap_done) begin
                nxt_d.cmd          = CMD_PRE;
                nxt_d.addr[AP_BIT] = 1'b1;
                ld                 = 1'b1;
                ld_val             = CNT_W'(T_RP - 1);
                nxt_d.state        = ST_AR_A;
            end
            ST_AR_A: if (gap_done) begin
                nxt_d.cmd   = CMD_REF;
                ld          = 1'b1;
                ld_val      = CNT_W'(T_RC - 1);
                nxt_d.state = ST_AR_B;
            end
            ST_AR_B: if (gap_done) begin
                nxt_d.cmd   = CMD_REF;
                ld          = 1'b1;
                ld_val      = CNT_W'(T_RC - 1);
                nxt_d.state = ST_MRS;
            end
            ST_MRS: if (gap_done) begin
                nxt_d.cmd   = CMD_MRS;
                nxt_d.addr  = MODE_WORD;
                ld          = 1'b1;
                ld_val      = CNT_W'(T_MRD - 1);
                nxt_d.state = ST_SETTLE;
            end
            ST_SETTLE: if (gap_done) begin
                nxt_d.ready = 1'b1;
                nxt_d.busy  = 1'b0;
                nxt_d.state = ST_IDLE;
            end
            ST_IDLE: if (ref_req && ref_gnt) begin
                nxt_d.cmd   = CMD_REF;
                nxt_d.busy  = 1'b1;
                ld          = 1'b1;
                ld_val      = CNT_W'(T_RC - 1);
                take        = 1'b1;
                nxt_d.state = ST_REF_GAP;
            end
            ST_REF_GAP: if (gap_done) begin
                nxt_d.busy  = 1'b0;
                nxt_d.state = ST_IDLE;
            end
            default: nxt_d.state = ST_CKE_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.state <= ST_CKE_ON;
            cur_q.cmd   <= CMD_NOP;
            cur_q.addr  <= '0;
            cur_q.ba    <= '0;
            cur_q.cke   <= 1'b0;
            cur_q.ready <= 1'b0;
            cur_q.busy  <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cur_q.cmd;
    assign addr  = cur_q.addr;
    assign ba    = cur_q.ba;
    assign cke   = cur_q.cke;
    assign ready = cur_q.ready;
    assign busy  = cur_q.busy;

    logic [3:0] pins;
    assign pins = {cs_n, ras_n, cas_n, we_n};

    AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (rst)
        (pins != CMD_NOP) |-> cke)
        else $error("command with clock enable low"); // R2

    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
        (pins == CMD_PRE) |-> addr[AP_BIT])
        else $error("precharge without all-bank bit"); // R3

    AST_CMD_SPACING: assert property (@(posedge clk) disable iff (rst)
        (pins != CMD_NOP) |=> (pins == CMD_NOP))
        else $error("back-to-back commands"); // R12

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready)
        else $error("ready dropped"); // R6

    AST_BUSY_IN_INIT: assert property (@(posedge clk) disable iff (rst)
        !ready |-> busy)
        else $error("busy low during start-up"); // R7

    AST_GNT_SERVED: assert property (@(posedge clk) disable iff (rst)
        (ready && !busy && ref_req && ref_gnt) |=> (pins == CMD_REF && !ref_req))
        else $error("granted refresh not issued"); // R9

endmodule

// File: tb/test_sdram_boot_refresh.sv
module test_sdram_boot_refresh;

    localparam int PW   = 5;
    localparam int REFI = 40;

    logic        clk = 1'b0;
    logic        rst;
    logic        ref_gnt;
    logic        cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic        ready, busy, ref_req;

    int checks = 0;
    int fails  = 0;
    int edge_n = 0;

    always #10 clk = ~clk;

    sdram_boot_refresh #(.PWRUP_WAIT(PW), .REFI(REFI)) i_sdram_boot_refresh (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .ready(ready), .busy(busy), .ref_req(ref_req)
    );

    typedef struct packed {
        logic [7:0]  cyc;
        logic [3:0]  cmd;
        logic [11:0] addr;
    } vec_t;

    // Start-up commands: edge index after reset release, pins, address
    localparam vec_t VEC [4] = '{
        '{8'd6,  4'b0010, 12'h400},
        '{8'd8,  4'b0001, 12'h000},
        '{8'd15, 4'b0001, 12'h000},
        '{8'd22, 4'b0000, 12'h222}
    };
    localparam int READY_EDGE = 24;

    task automatic step();
        @(posedge clk);
        edge_n++;
        @(negedge clk);
    endtask

    task automatic run_to(input int n);
        while (edge_n < n) step();
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at edge %0d: got 0x%0h expected 0x%0h", tag, edge_n, act, exp);
        end
    endtask

    function automatic logic [3:0] pins();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    initial begin
        #(20 * 5000);
        fails++;
        $display("FAIL watchdog expired at edge %0d", edge_n);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst     = 1'b1;
        ref_gnt = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cke",   cke,     1'b0);
        chk("R1 pins",  pins(),  4'b0111);
        chk("R1 ready", ready,   1'b0);
        chk("R1 busy",  busy,    1'b1);
        chk("R1 req",   ref_req, 1'b0);
        rst    = 1'b0;
        edge_n = 0;

        // Start-up sequence walked edge by edge against the vector table
        for (int k = 1; k <= 30; k++) begin
            logic [3:0]  ecmd;
            logic [11:0] eaddr;
            string       tag;
            step();
            ecmd  = 4'b0111;
            eaddr = 12'h000;
            for (int j = 0; j < 4; j++)
                if (int'(VEC[j].cyc) == k) begin
                    ecmd  = VEC[j].cmd;
                    eaddr = VEC[j].addr;
                end
            case (ecmd)
                4'b0010: tag = "R3 precharge";
                4'b0001: tag = "R4 auto-refresh";
                4'b0000: tag = "R5 mode load";
                default: tag = "R12 nop";
            endcase
            chk(tag, pins(), ecmd);
            chk(tag, addr, eaddr);
            chk("R12 ba", ba, 2'b00);
            chk("R2 cke", cke, 1'b1);
            chk("R6 ready", ready, k >= READY_EDGE);
            chk("R7 busy", busy, k < READY_EDGE);
            chk("R8 req idle", ref_req, 1'b0);
        end

        // R8: first request REFI edges after ready
        run_to(READY_EDGE + REFI - 1);
        chk("R8 req early", ref_req, 1'b0);
        step();
        chk("R8 req rise", ref_req, 1'b1);
        run_to(70);
        chk("R8 req held", ref_req, 1'b1);
        chk("R8 no cmd", pins(), 4'b0111);

        // R9: late grant
        ref_gnt = 1'b1;
        step();
        ref_gnt = 1'b0;
        chk("R9 refresh cmd", pins(), 4'b0001);
        chk("R9 req drop", ref_req, 1'b0);
        chk("R7 busy refresh", busy, 1'b1);
        run_to(77);
        chk("R7 busy last", busy, 1'b1);
        step();
        chk("R7 busy clear", busy, 1'b0);

        // R10: stray grant
        run_to(90);
        ref_gnt = 1'b1;
        step();
        ref_gnt = 1'b0;
        chk("R10 pins", pins(), 4'b0111);
        chk("R10 busy", busy, 1'b0);

        // R11: period not stretched by the late grant
        run_to(READY_EDGE + 2 * REFI - 1);
        chk("R11 req early", ref_req, 1'b0);
        step();
        chk("R11 req rise", ref_req, 1'b1);
        ref_gnt = 1'b1;
        step();
        chk("R9 refresh cmd 2", pins(), 4'b0001);

        // R11: grant held high before the third request
        run_to(READY_EDGE + 3 * REFI);
        chk("R11 req third", ref_req, 1'b1);
        step();
        ref_gnt = 1'b0;
        chk("R11 refresh cmd 3", pins(), 4'b0001);
        chk("R11 req drop", ref_req, 1'b0);

        // R1: reset mid-run restarts start-up
        run_to(160);
        rst = 1'b1;
        step();
        chk("R1 cke again",  cke,     1'b0);
        chk("R1 ready again", ready,  1'b0);
        chk("R1 busy again", busy,    1'b1);
        chk("R1 req again",  ref_req, 1'b0);
        chk("R1 pins again", pins(),  4'b0111);
        rst    = 1'b0;
        edge_n = 0;
        step();
        chk("R2 cke restart", cke, 1'b1);
        run_to(PW);
        chk("R2 wait nop", pins(), 4'b0111);
        step();
        chk("R3 precharge restart", pins(), 4'b0010);
        chk("R3 a10 restart", addr, 12'h400);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule